// File: doc/BRIEF.md
# INT8 Multiply-Accumulate Execution Unit

This block is the arithmetic back end of a small integer coprocessor attached to a RISC-V core. Each instruction brings two 32-bit source operands, a 32-bit accumulator value, a 2-bit operation code and a tag. The unit takes the low signed byte of each source, forms their 16-bit signed product, and then does one of four things. It can accumulate the product with byte saturation. It can accumulate it into a full 32-bit sum that wraps. It can return the product alone. It can also clamp the whole first operand to the signed byte range.

The pipeline holds no state between instructions. The running sum comes in as an operand on every issue and leaves as the result, so the core may issue speculatively and drop wrong-path work without any cleanup. Results leave in issue order after exactly three register stages. Each result carries its tag and a flag that is set whenever saturation changed the value. The result port uses valid/ready flow control. A flush input discards everything in flight.

Top module: `int8_mac_exec`

## Requirements
- R1: Operation code 2'b10 returns the 16-bit signed product of rs1[7:0] and rs2[7:0], sign-extended to 32 bits. Bits 31:8 of both sources do not affect it, and the overflow flag is 0.
- R2: Operation code 2'b01 returns accumulator plus the sign-extended product, modulo 2^32. The overflow flag is 0 even when the signed sum wraps.
- R3: Operation code 2'b00 computes accumulator plus product without wrapping. It limits that value to the range -128..127 and returns it sign-extended to 32 bits (127 is 32'h0000007F and -128 is 32'hFFFFFF80). The overflow flag is 1 exactly when the limit changed the value.
- R4: Operation code 2'b11 limits the full signed 32-bit rs1 to -128..127 and returns it sign-extended. The lower limit is 32'hFFFFFF80. The overflow flag is 1 exactly when the value was changed.
- R5: An instruction accepted on a clock edge appears on the result port after the third rising edge counted from the accepting one, provided the result port is ready and no flush occurs. It carries the tag it was issued with. Results come out in issue order.
- R6: While resValid is 1 and resReady is 0, the result value, tag and flag stay unchanged on the next cycle.
- R7: A cycle with flush high accepts no new instruction (issueReady is 0). All instructions in flight are discarded, including one waiting on the result port, so resValid is 0 on the following cycle.
- R8: During reset and on the first cycle after it, resValid is 0.
- R9: Whenever resReady is 1 and flush is 0, issueReady is 1, so one instruction per cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all in-flight instructions |
| issueValid | input | 1 | Instruction offered |
| issueReady | output | 1 | Instruction accepted this cycle when valid |
| issueOp | input | 2 | Operation code |
| issueRs1 | input | DATA_W (32) | First source operand |
| issueRs2 | input | DATA_W (32) | Second source operand |
| issueAcc | input | DATA_W (32) | Accumulator value |
| issueTag | input | TAG_W (4) | Instruction tag |
| resValid | output | 1 | Result present |
| resReady | input | 1 | Consumer takes the result |
| resRd | output | DATA_W (32) | Result value |
| resTag | output | TAG_W (4) | Tag of the result |
| resOvf | output | 1 | Saturation changed the result |

## Verification
The two events that can fall in the same cycle are a stalled result and a flush. Here the result is held on the port because resReady is low, and the flush arrives in that same cycle, possibly while resReady rises. The bench parks a result on a stalled port for several cycles and checks that it stays unchanged. It then raises flush and ready together. The bench expects the held result to be dropped rather than delivered, issueReady to be low in that cycle and resValid to be low on the next. The random phase produces the same overlap by chance, because it draws flush and a low ready independently, and the bench's reference queue, which is cleared on each flush, judges every result that follows.

// File: rtl/int8_mac_pkg.sv
`timescale 1ns/1ps
package int8_mac_pkg;

  typedef enum logic [1:0] {
    OP_MAC_SAT  = 2'b00,
    OP_MAC_WIDE = 2'b01,
    OP_MUL      = 2'b10,
    OP_CLAMP    = 2'b11
  } macOp_e;

  // strobes from the control path to the datapath
  typedef struct packed {
    logic loadS1;
    logic loadS2;
    logic loadS3;
  } stageStrobe_t;

endpackage

// File: rtl/int8_mac_sat.sv
`timescale 1ns/1ps
module int8_mac_sat #(
  parameter int IN_W  = 33,
  parameter int OUT_W = 8
) (
  input  logic signed [IN_W-1:0]  din,
  output logic        [OUT_W-1:0] dout,
  output logic                    clipped
);
  localparam int PAD_W = IN_W - OUT_W + 1;
  localparam logic signed [IN_W-1:0] MAX_V = $signed({{PAD_W{1'b0}}, {(OUT_W-1){1'b1}}});
  localparam logic signed [IN_W-1:0] MIN_V = $signed({{PAD_W{1'b1}}, {(OUT_W-1){1'b0}}});

  always_comb begin
    if (din > MAX_V) begin
      dout    = MAX_V[OUT_W-1:0];
      clipped = 1'b1;
    end else if (din < MIN_V) begin
      dout    = MIN_V[OUT_W-1:0];
      clipped = 1'b1;
    end else begin
      dout    = din[OUT_W-1:0];
      clipped = 1'b0;
    end
  end
endmodule

// File: rtl/int8_mac_ctrl.sv
`timescale 1ns/1ps
module int8_mac_ctrl
  import int8_mac_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         flush,
  input  logic         issueValid,
  output logic         issueReady,
  output logic         resValid,
  input  logic         resReady,
  output stageStrobe_t strobe
);
  logic [STAGES-1:0] stageValid;
  logic advance;
  logic takeIssue;

  assign advance    = !stageValid[STAGES-1] || resReady;
  assign issueReady = advance && !flush;
  assign takeIssue  = issueValid && issueReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageValid <= '0;
    end else if (flush) begin
      stageValid <= '0;
    end else if (advance) begin
      stageValid <= {stageValid[STAGES-2:0], takeIssue};
    end
  end

  assign strobe.loadS1 = takeIssue;
  assign strobe.loadS2 = advance && !flush && stageValid[0];
  assign strobe.loadS3 = advance && !flush && stageValid[1];
  assign resValid      = stageValid[STAGES-1];
endmodule

// File: rtl/int8_mac_dpath.sv
`timescale 1ns/1ps
module int8_mac_dpath
  import int8_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageStrobe_t      strobe,
  input  logic [1:0]        issueOp,
  input  logic [DATA_W-1:0] issueRs1,
  input  logic [DATA_W-1:0] issueRs2,
  input  logic [DATA_W-1:0] issueAcc,
  input  logic [TAG_W-1:0]  issueTag,
  output logic [DATA_W-1:0] resRd,
  output logic [TAG_W-1:0]  resTag,
  output logic              resOvf
);
  localparam int PROD_W = 2 * BYTE_W;
  localparam int SUM_W  = DATA_W + 1;

  // stage 1: operand capture
  macOp_e            s1Op;
  logic [DATA_W-1:0] s1Rs1, s1Rs2, s1Acc;
  logic [TAG_W-1:0]  s1Tag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Op <= OP_MAC_SAT; s1Rs1 <= '0; s1Rs2 <= '0; s1Acc <= '0; s1Tag <= '0;
    end else if (strobe.loadS1) begin
      s1Op  <= macOp_e'(issueOp);
      s1Rs1 <= issueRs1;
      s1Rs2 <= issueRs2;
      s1Acc <= issueAcc;
      s1Tag <= issueTag;
    end
  end

  // stage 2: signed byte product
  logic signed [BYTE_W-1:0] byteA, byteB;
  logic signed [PROD_W-1:0] prodNext;
  assign byteA    = $signed(s1Rs1[BYTE_W-1:0]);
  assign byteB    = $signed(s1Rs2[BYTE_W-1:0]);
  assign prodNext = PROD_W'(byteA) * PROD_W'(byteB);

  macOp_e                   s2Op;
  logic signed [PROD_W-1:0] s2Prod;
  logic [DATA_W-1:0]        s2Acc, s2Rs1;
  logic [TAG_W-1:0]         s2Tag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Op <= OP_MAC_SAT; s2Prod <= '0; s2Acc <= '0; s2Rs1 <= '0; s2Tag <= '0;
    end else if (strobe.loadS2) begin
      s2Op   <= s1Op;
      s2Prod <= prodNext;
      s2Acc  <= s1Acc;
      s2Rs1  <= s1Rs1;
      s2Tag  <= s1Tag;
    end
  end

  // stage 3: accumulate, select and saturate
  logic signed [SUM_W-1:0] prodExt, accExt, wideSum;
  logic [BYTE_W-1:0]       macByte, clampByte;
  logic                    macClip, clampClip;
  logic [DATA_W-1:0]       rdNext;
  logic                    ovfNext;

  assign prodExt = $signed({{(SUM_W-PROD_W){s2Prod[PROD_W-1]}}, s2Prod});
  assign accExt  = $signed({s2Acc[DATA_W-1], s2Acc});
  assign wideSum = accExt + prodExt;

  int8_mac_sat #(.IN_W(SUM_W), .OUT_W(BYTE_W)) macSat_i (
    .din(wideSum), .dout(macByte), .clipped(macClip)
  );

  int8_mac_sat #(.IN_W(DATA_W), .OUT_W(BYTE_W)) clampSat_i (
    .din($signed(s2Rs1)), .dout(clampByte), .clipped(clampClip)
  );

  always_comb begin
    unique case (s2Op)
      OP_MAC_SAT: begin
        rdNext  = {{(DATA_W-BYTE_W){macByte[BYTE_W-1]}}, macByte};
        ovfNext = macClip;
      end
      OP_MAC_WIDE: begin
        rdNext  = wideSum[DATA_W-1:0];
        ovfNext = 1'b0;
      end
      OP_MUL: begin
        rdNext  = {{(DATA_W-PROD_W){s2Prod[PROD_W-1]}}, s2Prod};
        ovfNext = 1'b0;
      end
      default: begin
        rdNext  = {{(DATA_W-BYTE_W){clampByte[BYTE_W-1]}}, clampByte};
        ovfNext = clampClip;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resRd <= '0; resTag <= '0; resOvf <= 1'b0;
    end else if (strobe.loadS3) begin
      resRd  <= rdNext;
      resTag <= s2Tag;
      resOvf <= ovfNext;
    end
  end
endmodule

// File: rtl/int8_mac_exec.sv
`timescale 1ns/1ps
module int8_mac_exec
  import int8_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              issueValid,
  output logic              issueReady,
  input  logic [1:0]        issueOp,
  input  logic [DATA_W-1:0] issueRs1,
  input  logic [DATA_W-1:0] issueRs2,
  input  logic [DATA_W-1:0] issueAcc,
  input  logic [TAG_W-1:0]  issueTag,
  output logic              resValid,
  input  logic              resReady,
  output logic [DATA_W-1:0] resRd,
  output logic [TAG_W-1:0]  resTag,
  output logic              resOvf
);
  stageStrobe_t strobe;

  int8_mac_ctrl #(.STAGES(3)) ctrl_i (
    .clk(clk), .rstN(rstN), .flush(flush),
    .issueValid(issueValid), .issueReady(issueReady),
    .resValid(resValid), .resReady(resReady), .strobe(strobe)
  );

  int8_mac_dpath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .TAG_W(TAG_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .issueOp(issueOp), .issueRs1(issueRs1), .issueRs2(issueRs2),
    .issueAcc(issueAcc), .issueTag(issueTag),
    .resRd(resRd), .resTag(resTag), .resOvf(resOvf)
  );
endmodule

// File: rtl/int8_mac_exec_chk.sv
`timescale 1ns/1ps
module int8_mac_exec_chk #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int TAG_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              flush,
  input logic              issueValid,
  input logic              issueReady,
  input logic [TAG_W-1:0]  issueTag,
  input logic              resValid,
  input logic              resReady,
  input logic [DATA_W-1:0] resRd,
  input logic [TAG_W-1:0]  resTag,
  input logic              resOvf
);
  localparam logic [DATA_W-1:0] POS_LIM = DATA_W'((1 << (BYTE_W-1)) - 1);
  localparam logic [DATA_W-1:0] NEG_LIM = ~POS_LIM;

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) && $past(issueValid && issueReady, 3)
    && $past(resReady, 1) && $past(resReady, 2)
    && !$past(flush, 1) && !$past(flush, 2)
    |-> resValid && (resTag == $past(issueTag, 3)));  // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resReady && !flush
    |=> resValid && $stable(resRd) && $stable(resTag) && $stable(resOvf));  // R6

  AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !resValid);  // R7

  AST_FLUSH_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !issueReady);  // R7

  AST_OVF_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    resValid && resOvf |-> (resRd == POS_LIM) || (resRd == NEG_LIM));  // R3

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> !resValid);  // R8

  AST_THROUGHPUT: assert property (@(posedge clk) disable iff (!rstN)
    resReady && !flush |-> issueReady);  // R9
endmodule

bind int8_mac_exec int8_mac_exec_chk #(
  .DATA_W(DATA_W), .BYTE_W(BYTE_W), .TAG_W(TAG_W)
) chk_i (
  .clk(clk), .rstN(rstN), .flush(flush), .issueValid(issueValid),
  .issueReady(issueReady), .issueTag(issueTag), .resValid(resValid),
  .resReady(resReady), .resRd(resRd), .resTag(resTag), .resOvf(resOvf)
);

// File: tb/int8_mac_exec_tb_top.sv
`timescale 1ns/1ps
module int8_mac_exec_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        issueValid = 1'b0;
  logic        issueReady;
  logic [1:0]  issueOp = 2'b00;
  logic [31:0] issueRs1 = '0, issueRs2 = '0, issueAcc = '0;
  logic [3:0]  issueTag = '0;
  logic        resValid;
  logic        resReady = 1'b0;
  logic [31:0] resRd;
  logic [3:0]  resTag;
  logic        resOvf;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [31:0] rd;
    logic [3:0]  tag;
    logic        ovf;
    logic [1:0]  op;
  } expRes_t;

  expRes_t     q[$];
  logic [3:0]  tagCnt = '0;
  bit          holdPend = 0;
  logic [31:0] heldRd;
  logic [3:0]  heldTag;
  logic        heldOvf;

  always #5 clk = ~clk;

  int8_mac_exec dut_i (
    .clk(clk), .rstN(rstN), .flush(flush),
    .issueValid(issueValid), .issueReady(issueReady), .issueOp(issueOp),
    .issueRs1(issueRs1), .issueRs2(issueRs2), .issueAcc(issueAcc),
    .issueTag(issueTag), .resValid(resValid), .resReady(resReady),
    .resRd(resRd), .resTag(resTag), .resOvf(resOvf)
  );

  function automatic string reqOf(logic [1:0] op);
    case (op)
      2'b00:   return "R3";
      2'b01:   return "R2";
      2'b10:   return "R1";
      default: return "R4";
    endcase
  endfunction

  function automatic expRes_t model(logic [1:0] op, logic [31:0] a, logic [31:0] b,
                                    logic [31:0] acc);
    expRes_t  e;
    longint   p, s;
    p = longint'($signed(a[7:0])) * longint'($signed(b[7:0]));
    e.op = op; e.ovf = 1'b0; e.tag = '0;
    case (op)
      2'b00: begin
        s = longint'($signed(acc)) + p;
        if (s > 127)       begin s = 127;  e.ovf = 1'b1; end
        else if (s < -128) begin s = -128; e.ovf = 1'b1; end
        e.rd = 32'(s);
      end
      2'b01: e.rd = 32'(longint'($signed(acc)) + p);
      2'b10: e.rd = 32'(p);
      default: begin
        s = longint'($signed(a));
        if (s > 127)       begin s = 127;  e.ovf = 1'b1; end
        else if (s < -128) begin s = -128; e.ovf = 1'b1; end
        e.rd = 32'(s);
      end
    endcase
    return e;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(logic iv, logic [1:0] op, logic [31:0] a, logic [31:0] b,
                      logic [31:0] acc, logic rdy, logic fl);
    expRes_t e;
    issueValid = iv; issueOp = op; issueRs1 = a; issueRs2 = b; issueAcc = acc;
    issueTag = tagCnt; resReady = rdy; flush = fl;
    #1;
    if (holdPend)
      check(resValid && resRd == heldRd && resTag == heldTag && resOvf == heldOvf,
            "R6", "stalled result changed", longint'(resRd), longint'(heldRd));
    if (fl) begin
      check(!issueReady, "R7", "issueReady during flush", longint'(issueReady), 0);
      q.delete();
    end else begin
      if (rdy) check(issueReady, "R9", "issueReady with port ready", longint'(issueReady), 1);
      if (resValid && rdy) begin
        if (q.size() == 0) begin
          check(0, "R5", "unexpected result", longint'(resTag), 0);
        end else begin
          e = q.pop_front();
          check(resRd == e.rd && resTag == e.tag && resOvf == e.ovf, reqOf(e.op),
                $sformatf("op=%0d tag=%0d ovf=%0b/%0b", e.op, resTag, resOvf, e.ovf),
                longint'(resRd), longint'(e.rd));
        end
      end
      if (iv && issueReady) begin
        e = model(op, a, b, acc);
        e.tag = tagCnt;
        q.push_back(e);
        tagCnt = tagCnt + 4'd1;
      end
    end
    holdPend = resValid && !rdy && !fl;
    heldRd = resRd; heldTag = resTag; heldOvf = resOvf;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n, logic rdy);
    for (int i = 0; i < n; i++) step(1'b0, 2'b00, '0, '0, '0, rdy, 1'b0);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    check(!resValid, "R8", "resValid in reset", longint'(resValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!resValid, "R8", "resValid after reset", longint'(resValid), 0);

    // R5 latency: accepted on edge 1, visible after edge 3
    step(1'b1, 2'b10, 32'd3, 32'd5, '0, 1'b1, 1'b0);
    check(!resValid, "R5", "early result after one edge", longint'(resValid), 0);
    idle(1, 1'b1);
    check(!resValid, "R5", "early result after two edges", longint'(resValid), 0);
    idle(1, 1'b1);
    check(resValid, "R5", "result after three edges", longint'(resValid), 1);
    idle(2, 1'b1);

    // directed corner cases, back to back
    step(1'b1, 2'b00, 32'hABCD_127F, 32'h0000_007F, 32'd0, 1'b1, 1'b0);       // R3 high clip
    step(1'b1, 2'b00, 32'd0, 32'd0, 32'hFFFF_FF38, 1'b1, 1'b0);                // R3 -200 -> -128
    step(1'b1, 2'b00, 32'd27, 32'd1, 32'd100, 1'b1, 1'b0);                     // R3 exactly 127
    step(1'b1, 2'b00, 32'h0000_0080, 32'h0000_0001, 32'd0, 1'b1, 1'b0);        // R3 exactly -128
    step(1'b1, 2'b00, 32'h0000_0080, 32'h0000_0080, 32'h8000_0000, 1'b1, 1'b0); // R3 no wrap
    step(1'b1, 2'b01, 32'd1, 32'd1, 32'h7FFF_FFFF, 1'b1, 1'b0);                // R2 wraps
    step(1'b1, 2'b10, 32'hFFFF_FF80, 32'h1234_5680, 32'd9, 1'b1, 1'b0);        // R1 -128*-128
    step(1'b1, 2'b11, 32'h8000_0000, 32'd0, 32'd0, 1'b1, 1'b0);                // R4 low clip
    step(1'b1, 2'b11, 32'hFFFF_FF80, 32'd0, 32'd0, 1'b1, 1'b0);                // R4 -128 kept
    step(1'b1, 2'b11, 32'h0000_0080, 32'd0, 32'd0, 1'b1, 1'b0);                // R4 128 -> 127
    idle(5, 1'b1);

    // R6/R7: result parked on a stalled port, then flush with ready rising
    step(1'b1, 2'b10, 32'd7, 32'd9, '0, 1'b0, 1'b0);
    idle(5, 1'b0);
    check(resValid, "R6", "held result present", longint'(resValid), 1);
    step(1'b0, 2'b00, '0, '0, '0, 1'b1, 1'b1);
    check(!resValid, "R7", "held result after flush", longint'(resValid), 0);

    // R7: two in flight then flush
    step(1'b1, 2'b01, 32'd2, 32'd3, 32'd4, 1'b1, 1'b0);
    step(1'b1, 2'b01, 32'd5, 32'd6, 32'd7, 1'b1, 1'b0);
    step(1'b1, 2'b01, 32'd5, 32'd6, 32'd7, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) begin
      check(!resValid, "R7", "result after flush", longint'(resValid), 0);
      idle(1, 1'b1);
    end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  op;
      logic [31:0] a, b, acc;
      op  = 2'($urandom_range(0, 3));
      a   = $urandom();
      b   = $urandom();
      acc = ($urandom_range(0, 3) == 0) ? $urandom() : 32'($urandom_range(0, 600)) - 32'd300;
      if (op == 2'b11 && $urandom_range(0, 1) == 1)
        a = 32'($urandom_range(0, 511)) - 32'd256;
      if ($urandom_range(0, 7) == 0) acc = 32'h7FFF_FF00 + 32'($urandom_range(0, 255));
      step(($urandom_range(0, 4) != 0), op, a, b, acc,
           ($urandom_range(0, 3) != 0), ($urandom_range(0, 40) == 0));
    end

    idle(8, 1'b1);
    check(q.size() == 0, "R5", "results outstanding after drain", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule